// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a byte-oriented SPI master that software drives through a small word-addressed register port. Bytes written to the transmit data register queue in a transmit FIFO. While the controller is enabled, the shift engine takes each queued byte and clocks it out on `mosi`. In the same frame it gathers eight bits from `miso`, and the finished byte goes into a receive FIFO, which software drains through the receive data register. Because every transmitted byte yields one received byte, software reads a slave by writing dummy bytes.

Software sets the serial clock polarity, the phase and a power-of-two clock divisor in the control register, and may change them only while the controller is disabled. Slave-select lines come straight from an active-low field of the control register. Shifting starts by itself whenever there is data to send, unless the manual-start option holds it until software asks. Sticky and live status flags feed one interrupt line through a mask, which software sets and clears with separate registers.

Top module: `spi_master_regs`

## Requirements
- R1: Registers sit at word offsets 0 control, 1 status, 2 mask-set, 3 mask-clear, 4 mask, 5 enable, 6 delay, 7 TX data, 8 RX data. After reset the control register reads 0x3C00, status reads 0x04, and mask, enable and delay read 0.
- R2: While a frame is in progress, `sclk` toggles once every 2^code clock cycles, where code is control bits 5:3. At all other times `sclk` rests at CPOL (control bit 1).
- R3: Frames are 8 bits, sent MSB first. `mosi` is stable on every sampling edge of `sclk`. With CPHA (control bit 2) clear, the sampling edges are the leading edges of the frame; with CPHA set, they are the trailing edges.
- R4: Each frame pushes exactly one byte into the RX FIFO. That byte holds the `miso` bits taken on the sampling edges, MSB first.
- R5: A frame starts only while enable register bit 0 and control bit 0 are both 1 and the TX FIFO is not empty. While enable bit 0 is 0, `sclk` does not move.
- R6: With control bit 15 set, queued bytes wait until a control write that carries bits 15 and 16 both set. Shifting then continues until the TX FIFO is empty.
- R7: With control bit 14 set, `ss_n[n]` equals control bit 10+n. With bit 14 clear, every `ss_n` line is 1.
- R8: While enable bit 0 is 1, a control write leaves bits 5:1 unchanged and updates the other bits.
- R9: A TX data write to a full FIFO drops the byte and sets status bit 6. Status bit 3 is high while the TX FIFO holds 128 bytes.
- R10: Status bit 4 is high while the RX FIFO is not empty, and bit 5 is high while it is full. A frame that ends with the RX FIFO full loses its byte and sets status bit 0. Reading RX data when the RX FIFO is empty returns 0.
- R11: Status bit 2 is high while the TX FIFO is empty. Writing ones to status clears those sticky bits (0 and 6).
- R12: Writing ones to mask-set sets those mask bits, and writing ones to mask-clear clears them. `irq` is high exactly when some status bit and its mask bit are both 1.
- R13: The delay register stores any 32-bit value written to it and has no effect on transfers.
- R14: Each FIFO holds 128 bytes and returns them in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data at offset 8) |
| reg_addr | input | 4 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench sweeps all four clock modes at three divisor codes. It uses a behavioural slave that records `mosi` on the edges the mode calls for and echoes it back, either straight or inverted. A phase error shows up as a byte shifted by one bit, and a divisor error shows up as a wrong spacing between `sclk` edges. A stall in manual-start mode and frames that start while the controller is disabled are caught by watching for `sclk` activity. The bench also fills the TX FIFO one byte past full and then drains 128 frames into a full RX FIFO. A design with an off-by-one depth, a missing drop or a lost sticky flag would return the wrong byte sequence or a clear overflow bit there. A mode field that is not locked while enabled would change the read-back value and the idle level of `sclk`.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // word offsets of the register file
  localparam logic [3:0] OFF_CTRL = 4'd0;
  localparam logic [3:0] OFF_ISR  = 4'd1;
  localparam logic [3:0] OFF_IER  = 4'd2;
  localparam logic [3:0] OFF_IDR  = 4'd3;
  localparam logic [3:0] OFF_IMR  = 4'd4;
  localparam logic [3:0] OFF_ENR  = 4'd5;
  localparam logic [3:0] OFF_DLY  = 4'd6;
  localparam logic [3:0] OFF_TXD  = 4'd7;
  localparam logic [3:0] OFF_RXD  = 4'd8;

  // control bit positions
  localparam int CB_MASTER = 0;
  localparam int CB_CPOL   = 1;
  localparam int CB_CPHA   = 2;
  localparam int CB_DIV    = 3;
  localparam int DIV_W     = 3;
  localparam int CB_SS     = 10;
  localparam int SS_FIELD  = 4;
  localparam int CB_MANCS  = 14;
  localparam int CB_MANST  = 15;
  localparam int CB_GO     = 16;
  localparam logic [15:0] CTRL_WMASK = 16'hFC3F;
  localparam logic [15:0] CTRL_RESET = 16'h3C00;

  // status bit positions
  localparam int ISR_W      = 7;
  localparam int IB_RXOVF   = 0;
  localparam int IB_TXLOW   = 2;
  localparam int IB_TXFULL  = 3;
  localparam int IB_RXNE    = 4;
  localparam int IB_RXFULL  = 5;
  localparam int IB_TXOVF   = 6;

  // half period of sclk in reference clocks for a divisor code
  function automatic int unsigned spim_half(input int unsigned code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic [$clog2(DEPTH):0]       level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (level == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (level != '0);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter import spim_pkg::*; #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [DIV_W-1:0]   div_code,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               busy,
  output logic               edge_tick,
  output logic               sample_tick,
  output logic               frame_done,
  output logic               rx_valid,
  output logic [FRAME_W-1:0] rx_byte
);
  localparam int CNT_W  = 1 << DIV_W;
  localparam int EDGES  = 2 * FRAME_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic [CNT_W-1:0]   div_cnt, half_m1;
  logic [EDGE_W-1:0]  edge_idx;
  logic [FRAME_W-1:0] tx_sh, rx_sh;
  logic               sclk_q, busy_q, rxv_q, shift_tick, last_edge;

  assign half_m1     = CNT_W'(spim_half(32'(div_code)) - 32'd1);
  assign edge_tick   = busy_q && en && (div_cnt == half_m1);
  assign last_edge   = (edge_idx == EDGE_W'(EDGES - 1));
  assign sample_tick = edge_tick && (edge_idx[0] == cpha);
  assign shift_tick  = edge_tick && (edge_idx[0] != cpha) &&
                       (edge_idx != '0) && !last_edge;
  assign frame_done  = edge_tick && last_edge;

  assign sclk     = sclk_q;
  assign mosi     = tx_sh[FRAME_W-1];
  assign busy     = busy_q;
  assign rx_valid = rxv_q;
  assign rx_byte  = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      busy_q   <= 1'b0;
      rxv_q    <= 1'b0;
      div_cnt  <= '0;
      edge_idx <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else begin
      rxv_q <= frame_done;
      if (!en || !busy_q) begin
        sclk_q   <= cpol;
        div_cnt  <= '0;
        edge_idx <= '0;
        busy_q   <= en && start;
        if (en && start) tx_sh <= tx_byte;
      end else if (edge_tick) begin
        sclk_q   <= ~sclk_q;
        div_cnt  <= '0;
        edge_idx <= edge_idx + 1'b1;
        if (sample_tick) rx_sh <= {rx_sh[FRAME_W-2:0], miso};
        if (shift_tick)  tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        if (last_edge)   busy_q <= 1'b0;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs import spim_pkg::*; #(
  parameter int FIFO_DEPTH = 128,
  parameter int NUM_SS     = 3,
  parameter int TX_THRESH  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n,
  output logic              irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  logic [15:0]      ctrl_q, ctrl_nx;
  logic             enr_q, man_go_q;
  logic [31:0]      dly_q;
  logic [ISR_W-1:0] imr_q, sticky_q, isr_live, isr_val, isr_ev;

  // named events of the register port
  logic wr_ctrl, wr_isr, wr_ier, wr_idr, wr_enr, wr_dly, wr_txd, rd_rxd;
  assign wr_ctrl = reg_wr && (reg_addr == OFF_CTRL);
  assign wr_isr  = reg_wr && (reg_addr == OFF_ISR);
  assign wr_ier  = reg_wr && (reg_addr == OFF_IER);
  assign wr_idr  = reg_wr && (reg_addr == OFF_IDR);
  assign wr_enr  = reg_wr && (reg_addr == OFF_ENR);
  assign wr_dly  = reg_wr && (reg_addr == OFF_DLY);
  assign wr_txd  = reg_wr && (reg_addr == OFF_TXD);
  assign rd_rxd  = reg_rd && (reg_addr == OFF_RXD);

  // FIFOs and shift engine
  logic [7:0]       tx_dout, rx_dout, rx_byte;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic             tx_full, rx_full, tx_empty, rx_empty;
  logic             xfer_en, go, start, busy, rx_valid;
  logic             edge_tick, sample_tick, frame_done;
  logic             rx_rd_empty;

  assign tx_empty    = (tx_level == '0);
  assign rx_empty    = (rx_level == '0);
  assign xfer_en     = enr_q && ctrl_q[CB_MASTER];
  assign go          = ctrl_q[CB_MANST] ? man_go_q : 1'b1;
  assign start       = xfer_en && go && !tx_empty && !busy;
  assign rx_rd_empty = rd_rxd && rx_empty;

  spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_txd), .din(reg_wdata[7:0]),
    .pop(start), .dout(tx_dout), .full(tx_full), .level(tx_level));

  spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_valid), .din(rx_byte),
    .pop(rd_rxd), .dout(rx_dout), .full(rx_full), .level(rx_level));

  spim_shifter #(.FRAME_W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(xfer_en),
    .cpol(ctrl_q[CB_CPOL]), .cpha(ctrl_q[CB_CPHA]),
    .div_code(ctrl_q[CB_DIV +: DIV_W]), .start(start), .tx_byte(tx_dout),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy),
    .edge_tick(edge_tick), .sample_tick(sample_tick),
    .frame_done(frame_done), .rx_valid(rx_valid), .rx_byte(rx_byte));

  // control write with the mode/divisor lock while enabled
  always_comb begin
    ctrl_nx = reg_wdata[15:0] & CTRL_WMASK;
    if (enr_q) ctrl_nx[CB_DIV+DIV_W-1:CB_CPOL] = ctrl_q[CB_DIV+DIV_W-1:CB_CPOL];
  end

  // status assembly
  always_comb begin
    isr_live = '0;
    isr_live[IB_TXLOW]  = (tx_level < LVL_W'(TX_THRESH));
    isr_live[IB_TXFULL] = tx_full;
    isr_live[IB_RXNE]   = !rx_empty;
    isr_live[IB_RXFULL] = rx_full;
    isr_ev = '0;
    isr_ev[IB_RXOVF] = rx_valid && rx_full;
    isr_ev[IB_TXOVF] = wr_txd && tx_full;
  end
  assign isr_val = sticky_q | isr_live;
  assign irq     = |(isr_val & imr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      enr_q    <= 1'b0;
      dly_q    <= '0;
      imr_q    <= '0;
      sticky_q <= '0;
      man_go_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_nx;
      if (wr_enr)  enr_q  <= reg_wdata[0];
      if (wr_dly)  dly_q  <= reg_wdata;
      if (wr_ier)       imr_q <= imr_q | reg_wdata[ISR_W-1:0];
      else if (wr_idr)  imr_q <= imr_q & ~reg_wdata[ISR_W-1:0];
      sticky_q <= (wr_isr ? (sticky_q & ~reg_wdata[ISR_W-1:0]) : sticky_q) | isr_ev;
      if (wr_ctrl && reg_wdata[CB_GO] && reg_wdata[CB_MANST]) man_go_q <= 1'b1;
      else if (tx_empty && !busy)                             man_go_q <= 1'b0;
    end
  end

  // slave selects, one per output
  for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
    assign ss_n[g] = ctrl_q[CB_MANCS] ? ctrl_q[CB_SS + g] : 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CTRL: reg_rdata = {16'b0, ctrl_q};
      OFF_ISR:  reg_rdata = {{(32-ISR_W){1'b0}}, isr_val};
      OFF_IMR:  reg_rdata = {{(32-ISR_W){1'b0}}, imr_q};
      OFF_ENR:  reg_rdata = {31'b0, enr_q};
      OFF_DLY:  reg_rdata = dly_q;
      OFF_RXD:  reg_rdata = rx_empty ? 32'b0 : {24'b0, rx_dout};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_sva.sv
module spim_sva #(
  parameter int ISR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             sclk,
  input logic             cpol,
  input logic             xfer_en,
  input logic             wr_txd,
  input logic             tx_full,
  input logic [ISR_W-1:0] sticky_q,
  input logic [ISR_W-1:0] imr_q,
  input logic             irq,
  input logic             frame_done,
  input logic             rx_valid,
  input logic             rx_rd_empty,
  input logic [31:0]      reg_rdata
);
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $stable(cpol)) |-> (sclk == cpol));

  p_halt_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> !busy);

  p_frame_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_valid);

  p_tx_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && tx_full) |=> sticky_q[6]);

  p_rx_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_empty |-> (reg_rdata == 32'b0));

  p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q == '0) |-> !irq);
endmodule

bind spi_master_regs spim_sva #(.ISR_W(7)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .cpol(ctrl_q[1]),
  .xfer_en(xfer_en), .wr_txd(wr_txd), .tx_full(tx_full), .sticky_q(sticky_q),
  .imr_q(imr_q), .irq(irq), .frame_done(frame_done), .rx_valid(rx_valid),
  .rx_rd_empty(rx_rd_empty), .reg_rdata(reg_rdata));

// File: tb/spi_master_regs_tb.sv
module spi_master_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, mosi, miso;
  logic [2:0]  ss_n;
  logic        irq;
  logic        tb_inv = 1'b0;

  int checks = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign miso = mosi ^ tb_inv;

  spi_master_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .irq(irq));

  // behavioural slave monitor
  int  cyc = 0, last_cyc = 0, edge_no = 0, ncap = 0, gap_err = 0, exp_half = 1;
  int  sclk_moves = 0;
  bit  mon_on = 0;
  logic tb_cpol = 0, tb_cpha = 0;
  logic [7:0] cap_sh = 0;
  logic [7:0] cap [8];

  always @(posedge clk) cyc = cyc + 1;

  always @(sclk) begin
    if (rst_n) sclk_moves++;
    if (mon_on) begin
      if ((edge_no % 16) != 0 && (cyc - last_cyc) != exp_half) gap_err++;
      last_cyc = cyc;
      if (sclk == (tb_cpol ~^ tb_cpha)) cap_sh = {cap_sh[6:0], mosi};
      edge_no++;
      if ((edge_no % 16) == 0) begin
        if (ncap < 8) cap[ncap] = cap_sh;
        ncap++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  txb [3];
    int moves0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset values
    rd(4'd0, v); chk("R1 ctrl reset", v, 32'h3C00);
    rd(4'd1, v); chk("R1 status reset", v, 32'h04);
    rd(4'd4, v); chk("R1 mask reset", v, 32'h0);
    rd(4'd5, v); chk("R1 enable reset", v, 32'h0);
    rd(4'd6, v); chk("R1 delay reset", v, 32'h0);
    chk("R7 ss idle at reset", {29'b0, ss_n}, 32'h7);
    chk("R1 sclk reset", {31'b0, sclk}, 32'h0);
    chk("R12 irq reset", {31'b0, irq}, 32'h0);

    // R2 R3 R4 sweep of modes and divisor codes
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 3; c++) begin
        mon_on = 0;
        wr(4'd5, 32'h0);
        tb_cpol = m[1]; tb_cpha = m[0]; tb_inv = c[0];
        exp_half = 1 << c;
        wr(4'd0, 32'h1 | (32'(m[1]) << 1) | (32'(m[0]) << 2) | (32'(c) << 3) |
                 (32'h1 << 14) | (32'hE << 10));
        idle(2);
        edge_no = 0; ncap = 0; gap_err = 0;
        mon_on = 1;
        wr(4'd5, 32'h1);
        for (int i = 0; i < 3; i++) begin
          txb[i] = 8'((m * 64) + (c * 16) + (i * 85) + 8'h3C);
          wr(4'd7, {24'b0, txb[i]});
        end
        idle(3 * (16 * exp_half + 4) + 10);
        chk("R7 ss select", {29'b0, ss_n}, 32'h6);
        chk("R2 idle level", {31'b0, sclk}, {31'b0, tb_cpol});
        chk("R2 half period spacing", gap_err, 0);
        chk("R4 frame count", ncap, 3);
        for (int i = 0; i < 3; i++) begin
          chk("R3 mosi msb first", {24'b0, cap[i]}, {24'b0, txb[i]});
          rd(4'd8, v);
          chk("R4 rx byte", v, {24'b0, tb_inv ? ~txb[i] : txb[i]});
        end
        rd(4'd1, v);
        chk("R10 rx drained", v & 32'h10, 32'h0);
      end
    end
    mon_on = 0;

    // R8 mode lock while enabled (last config: cpol1 cpha1 code2)
    wr(4'd0, 32'h1 | (32'h5 << 3) | (32'h1 << 14) | (32'hD << 10));
    idle(2);
    rd(4'd0, v);
    chk("R8 locked mode bits", v, 32'h7417);
    chk("R8 sclk keeps old level", {31'b0, sclk}, 32'h1);
    chk("R7 ss second slave", {29'b0, ss_n}, 32'h5);

    // R7 select field sweep while disabled
    wr(4'd5, 32'h0);
    for (int f = 0; f < 16; f++) begin
      wr(4'd0, 32'h1 | (32'h1 << 14) | (32'(f) << 10));
      chk("R7 ss follows field", {29'b0, ss_n}, 32'(f & 7));
    end
    wr(4'd0, 32'h1 | (32'h0 << 10));
    chk("R7 ss released", {29'b0, ss_n}, 32'h7);

    // R13 delay register
    wr(4'd6, 32'hA5A5_5A5A);
    rd(4'd6, v); chk("R13 delay holds", v, 32'hA5A5_5A5A);

    // R6 manual start
    tb_inv = 0;
    wr(4'd0, 32'h1 | (32'h1 << 14) | (32'h1 << 15) | (32'hE << 10));
    wr(4'd5, 32'h1);
    moves0 = sclk_moves;
    wr(4'd7, 32'hC3);
    idle(60);
    chk("R6 held before go", sclk_moves - moves0, 0);
    rd(4'd1, v); chk("R6 tx still queued", v & 32'h14, 32'h0);
    wr(4'd0, 32'h1 | (32'h1 << 14) | (32'h1 << 15) | (32'h1 << 16) | (32'hE << 10));
    idle(40);
    chk("R6 frame after go", sclk_moves - moves0, 16);
    rd(4'd8, v); chk("R6 rx after go", v, 32'hC3);

    // R5 R9 R14 fill while disabled
    wr(4'd5, 32'h0);
    wr(4'd0, 32'h1 | (32'h1 << 14) | (32'hE << 10));
    idle(2);
    moves0 = sclk_moves;
    for (int i = 0; i < 129; i++) wr(4'd7, 32'(i));
    chk("R5 no sclk while disabled", sclk_moves - moves0, 0);
    rd(4'd1, v); chk("R9 overflow and full flags", v, 32'h48);
    chk("R12 irq unmasked off", {31'b0, irq}, 32'h0);
    wr(4'd2, 32'h40);
    rd(4'd4, v); chk("R12 mask set", v, 32'h40);
    chk("R12 irq on", {31'b0, irq}, 32'h1);
    wr(4'd1, 32'h40);
    rd(4'd1, v); chk("R11 w1c overflow", v, 32'h08);
    chk("R12 irq after clear", {31'b0, irq}, 32'h0);
    wr(4'd3, 32'h40);
    rd(4'd4, v); chk("R12 mask clear", v, 32'h0);
    wr(4'd2, 32'h10);

    // drain 128 frames into the receive FIFO
    wr(4'd5, 32'h1);
    idle(128 * 20 + 60);
    rd(4'd1, v); chk("R10 rx full flags", v, 32'h34);
    chk("R12 irq rx not empty", {31'b0, irq}, 32'h1);
    wr(4'd7, 32'hEE);
    idle(40);
    rd(4'd1, v); chk("R10 rx overflow sticky", v & 32'h01, 32'h01);
    for (int i = 0; i < 128; i++) begin
      rd(4'd8, v);
      chk("R14 fifo order", v, 32'(i));
    end
    rd(4'd8, v); chk("R10 empty read zero", v, 32'h0);
    rd(4'd1, v); chk("R11 status after drain", v, 32'h05);
    chk("R12 irq drops when empty", {31'b0, irq}, 32'h0);
    wr(4'd1, 32'h01);
    rd(4'd1, v); chk("R11 w1c rx overflow", v, 32'h04);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule